// File: doc/BRIEF.md
# Cascaded SRAM Write Command Sequencer

This block lives in one search-engine device of a cascade of up to 31 devices that share a host command bus. It watches the host bus for an SRAM Write command. The command opens with a two-phase first cycle, phase A and then phase B, and is followed by two filler cycles. The block decides whether the command addresses this device and the SRAM space. If so, it replays the write on the external SRAM bus after a fixed pipeline latency. That latency is the same as the search latency and is counted from phase B. On that one cycle the block drives the assembled 22-bit SRAM address and pulls the chip-enable, write-enable and address-latch strobes low.

The host bus is modelled at the command clock. Phase A, phase B and the two filler cycles each take one clock, so a write command occupies four clocks. A new command may start on the clock after the last filler cycle. Because the replay is pipelined, a later command can already be decoding while an earlier write is still travelling down the latency line. When the block is not emitting a write it releases the SRAM bus: `sram_drive` is low and the strobes sit at their inactive high level.

The decoder is a four-state machine:
- **IDLE** moves to **PHASE_B** when a write opcode arrives with the command-valid input high. Otherwise it stays in IDLE.
- **PHASE_B** moves to **FILL_1** if phase B again carries a valid write opcode. In that case a write is launched if every selection condition holds. Otherwise PHASE_B aborts back to **IDLE**.
- **FILL_1** always moves to **FILL_2**.
- **FILL_2** always returns to **IDLE**.

Top module: `sram_wr_seq`

## Requirements
- R1: A write is launched only if `cmd_valid` is 1 and `cmd_op` equals 2'b01 in phase A and again in phase B. If phase B fails this test, the command is dropped and the decoder is free again on the next clock.
- R2: The space select field `host_dq[20:19]` must equal 2'b10 in both phase A and phase B. Any other value launches nothing.
- R3: The device ID field `host_dq[25:21]` in phase A must equal `dev_id`. Otherwise nothing is launched.
- R4: The burst flag `cmd_burst` must be 0 in both phases. A command with the flag set in either phase launches nothing.
- R5: The emitted address takes bits [21:19] from `cmd_hiaddr` and bits [18:0] from `host_dq[18:0]`, both captured in phase A.
- R6: Inputs during the two filler cycles are ignored, including a write opcode with `cmd_valid` high.
- R7: `cmd_busy` is high for the three clocks after phase A is taken (phase B and both filler cycles), or for one clock if phase B aborts. A new phase A is accepted on the clock after the last filler cycle, which gives one command every four clocks.
- R8: If phase B of a launched write is in clock n, the strobes appear in clock n+LAT (default LAT = 4).
- R9: A launched write drives `sram_ce_n`, `sram_we_n` and `sram_ale_n` low and `sram_drive` high for exactly one clock. At all other times the strobes are high, `sram_drive` is low and `sram_addr` is 0.
- R10: A write still in the latency line is emitted unchanged while a following command is being decoded in the same clock.
- R11: Synchronous active-high `rst` returns the decoder to IDLE and discards every in-flight write. No strobe appears afterwards until a new valid command completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst | input | 1 | Synchronous reset, active high |
| dev_id | input | 5 | This device's position in the cascade |
| cmd_valid | input | 1 | Host command valid |
| cmd_op | input | 2 | Opcode, 2'b01 = write |
| cmd_burst | input | 1 | Burst flag, must be 0 |
| cmd_hiaddr | input | 3 | Upper SRAM address bits (phase A) |
| host_dq | input | 26 | Device ID [25:21], space select [20:19], low address [18:0] |
| cmd_busy | output | 1 | Command in progress, new command not accepted |
| sram_addr | output | 22 | SRAM address during the write cycle |
| sram_ce_n | output | 1 | SRAM chip enable, active low |
| sram_we_n | output | 1 | SRAM write enable, active low |
| sram_ale_n | output | 1 | Address latch enable, active low |
| sram_drive | output | 1 | High while this device owns the SRAM bus |

## Verification
With LAT at its default of 4, commands sent back to back put each write's replay on the SRAM bus in the same clock that the next command's phase B is sampled. One clock can therefore hold both an emission from the latency line and a launch into it. The bench streams valid writes with no gaps so that this overlap happens repeatedly. It also fills the filler cycles with write opcodes and random bus data. A behavioural model, built from queued due times, checks every clock that the emitted address belongs to the older write and that the newer write appears four clocks later.

// File: rtl/sram_wr_pkg.sv
package sram_wr_pkg;

    localparam int HI_W   = 3;
    localparam int LO_W   = 19;
    localparam int ADDR_W = HI_W + LO_W;

    localparam logic [1:0] OP_WRITE   = 2'b01;
    localparam logic [1:0] SPACE_SRAM = 2'b10;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PHASE_B,
        ST_FILL_1,
        ST_FILL_2
    } seq_state_t;

    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] addr;
    } wr_slot_t;

endpackage

// File: rtl/sram_wr_decode.sv
module sram_wr_decode
    import sram_wr_pkg::*;
#(
    parameter  int ID_W = 5,
    localparam int DQ_W = ID_W + 2 + LO_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ID_W-1:0]   dev_id,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic              cmd_burst,
    input  logic [HI_W-1:0]   cmd_hiaddr,
    input  logic [DQ_W-1:0]   host_dq,
    output logic              busy,
    output logic              launch,
    output logic [ADDR_W-1:0] launch_addr
);

    seq_state_t        state_q, state_d;
    logic              a_ok_q;
    logic [ADDR_W-1:0] addr_q;
    logic              is_write, space_hit, id_hit;

    assign is_write  = cmd_valid && (cmd_op == OP_WRITE);
    assign space_hit = (host_dq[LO_W+1:LO_W] == SPACE_SRAM);
    assign id_hit    = (host_dq[DQ_W-1:LO_W+2] == dev_id);

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (is_write) state_d = ST_PHASE_B;
            ST_PHASE_B: state_d = is_write ? ST_FILL_1 : ST_IDLE;
            ST_FILL_1:  state_d = ST_FILL_2;
            ST_FILL_2:  state_d = ST_IDLE;
        endcase
    end

    // phase A capture of selection and address
    always_ff @(posedge clk) begin
        if (rst) begin
            a_ok_q <= 1'b0;
            addr_q <= '0;
        end else if (state_q == ST_IDLE && is_write) begin
            a_ok_q <= id_hit && space_hit && !cmd_burst;
            addr_q <= {cmd_hiaddr, host_dq[LO_W-1:0]};
        end
    end

    // outputs
    always_comb begin
        busy        = (state_q != ST_IDLE);
        launch      = (state_q == ST_PHASE_B) && is_write && a_ok_q
                      && space_hit && !cmd_burst;
        launch_addr = addr_q;
    end

    assert_phase_b_exit_R1: assert property (@(posedge clk) disable iff (rst)
        state_q == ST_PHASE_B |=> (state_q == ST_FILL_1 || state_q == ST_IDLE));
    assert_fill_chain_R7: assert property (@(posedge clk) disable iff (rst)
        state_q == ST_FILL_1 |=> state_q == ST_FILL_2);
    assert_fill_end_R6: assert property (@(posedge clk) disable iff (rst)
        state_q == ST_FILL_2 |=> state_q == ST_IDLE);

endmodule

// File: rtl/sram_wr_delay.sv
module sram_wr_delay
    import sram_wr_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic     clk,
    input  logic     rst,
    input  wr_slot_t slot_in,
    output wr_slot_t slot_out
);

    wr_slot_t slot_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q[0].vld  <= 1'b0;
            slot_q[0].addr <= '0;
        end else begin
            slot_q[0] <= slot_in;
        end
    end

    for (genvar g = 1; g < DEPTH; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q[g].vld  <= 1'b0;
                slot_q[g].addr <= '0;
            end else begin
                slot_q[g] <= slot_q[g-1];
            end
        end

        assert_shift_R8: assert property (@(posedge clk) disable iff (rst)
            slot_q[g-1].vld |=> slot_q[g].vld);
    end

    assign slot_out = slot_q[DEPTH-1];

endmodule

// File: rtl/sram_wr_seq.sv
module sram_wr_seq
    import sram_wr_pkg::*;
#(
    parameter  int ID_W = 5,
    parameter  int LAT  = 4,
    localparam int DQ_W = ID_W + 2 + LO_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ID_W-1:0]   dev_id,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic              cmd_burst,
    input  logic [HI_W-1:0]   cmd_hiaddr,
    input  logic [DQ_W-1:0]   host_dq,
    output logic              cmd_busy,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_ce_n,
    output logic              sram_we_n,
    output logic              sram_ale_n,
    output logic              sram_drive
);

    logic              launch;
    logic [ADDR_W-1:0] launch_addr;
    wr_slot_t          slot_in, slot_out;

    sram_wr_decode #(.ID_W(ID_W)) u_decode (
        .clk        (clk),
        .rst        (rst),
        .dev_id     (dev_id),
        .cmd_valid  (cmd_valid),
        .cmd_op     (cmd_op),
        .cmd_burst  (cmd_burst),
        .cmd_hiaddr (cmd_hiaddr),
        .host_dq    (host_dq),
        .busy       (cmd_busy),
        .launch     (launch),
        .launch_addr(launch_addr)
    );

    assign slot_in.vld  = launch;
    assign slot_in.addr = launch_addr;

    sram_wr_delay #(.DEPTH(LAT)) u_delay (
        .clk     (clk),
        .rst     (rst),
        .slot_in (slot_in),
        .slot_out(slot_out)
    );

    always_comb begin
        sram_drive = slot_out.vld;
        sram_ce_n  = !slot_out.vld;
        sram_we_n  = !slot_out.vld;
        sram_ale_n = !slot_out.vld;
        sram_addr  = slot_out.vld ? slot_out.addr : '0;
    end

    assert_single_strobe_R9: assert property (@(posedge clk) disable iff (rst)
        !sram_ce_n |=> sram_ce_n);
    assert_reset_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (sram_ce_n && !sram_drive));
    assert_launch_free_R10: assert property (@(posedge clk) disable iff (rst)
        launch |=> !launch);

endmodule

// File: tb/sram_wr_seq_tb.sv
`timescale 1ns/1ps
module sram_wr_seq_tb;

    localparam int LAT = 4;
    localparam logic [4:0] MY_ID = 5'd7;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  dev_id = MY_ID;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'b00;
    logic        cmd_burst = 1'b0;
    logic [2:0]  cmd_hiaddr = 3'd0;
    logic [25:0] host_dq = '0;
    logic        cmd_busy;
    logic [21:0] sram_addr;
    logic        sram_ce_n, sram_we_n, sram_ale_n, sram_drive;

    int n_tests = 0;
    int n_fail  = 0;
    int edge_n  = 0;
    bit done    = 1'b0;

    typedef struct {
        int          due;
        logic [21:0] addr;
    } exp_t;
    exp_t exp_q[$];
    int          mphase = 0;
    bit          a_ok = 1'b0;
    logic [21:0] a_addr = '0;

    always #2.5 clk = ~clk;

    sram_wr_seq #(.ID_W(5), .LAT(LAT)) u_dut (
        .clk(clk), .rst(rst), .dev_id(dev_id), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_burst(cmd_burst), .cmd_hiaddr(cmd_hiaddr),
        .host_dq(host_dq), .cmd_busy(cmd_busy), .sram_addr(sram_addr),
        .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n), .sram_ale_n(sram_ale_n),
        .sram_drive(sram_drive)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s at edge %0d: actual %h expected %h", req, what, edge_n, act, exp);
        end
    endtask

    // reference model: updated on each rising edge
    always @(posedge clk) begin
        edge_n++;
        if (rst) begin
            mphase = 0;
            exp_q.delete();
        end else begin
            case (mphase)
                0: if (cmd_valid && cmd_op == 2'b01) begin
                       a_ok   = (host_dq[25:21] == dev_id) && (host_dq[20:19] == 2'b10) && !cmd_burst;
                       a_addr = {cmd_hiaddr, host_dq[18:0]};
                       mphase = 1;
                   end
                1: if (cmd_valid && cmd_op == 2'b01) begin
                       if (a_ok && host_dq[20:19] == 2'b10 && !cmd_burst)
                           exp_q.push_back('{edge_n + LAT - 1, a_addr});
                       mphase = 2;
                   end else mphase = 0;
                2: mphase = 3;
                default: mphase = 0;
            endcase
        end
    end

    // compare on every falling edge
    always @(negedge clk) begin
        if (!done) begin
            bit          es;
            logic [21:0] ea;
            es = (exp_q.size() > 0) && (exp_q[0].due == edge_n);
            ea = es ? exp_q[0].addr : 22'd0;
            chk(sram_ce_n == !es, "R8", "ce_n timing", 32'(sram_ce_n), 32'(!es));
            chk(sram_we_n == !es && sram_ale_n == !es, "R9", "we_n/ale_n",
                {30'd0, sram_we_n, sram_ale_n}, {30'd0, !es, !es});
            chk(sram_drive == es, "R9", "drive", 32'(sram_drive), 32'(es));
            chk(sram_addr == ea, "R5", "address", 32'(sram_addr), 32'(ea));
            chk(cmd_busy == (mphase != 0), "R7", "busy", 32'(cmd_busy), 32'(mphase != 0));
            if (es) void'(exp_q.pop_front());
        end
    end

    task automatic put(input logic v, input logic [1:0] op, input logic b,
                       input logic [2:0] hi, input logic [25:0] d);
        @(negedge clk);
        cmd_valid = v; cmd_op = op; cmd_burst = b; cmd_hiaddr = hi; host_dq = d;
    endtask

    // one four-clock write command; fill_wr puts a write opcode in the filler cycles (R6)
    task automatic wr(input logic [4:0] id, input logic [1:0] sp_a, input logic [1:0] sp_b,
                      input logic b_a, input logic b_b, input logic v_b, input logic [1:0] op_b,
                      input logic [2:0] hi, input logic [18:0] lo, input bit fill_wr);
        put(1'b1, 2'b01, b_a, hi, {id, sp_a, lo});
        put(v_b, op_b, b_b, 3'($urandom), {id, sp_b, 19'($urandom)});
        put(fill_wr, 2'b01, 1'b0, 3'($urandom), 26'($urandom));
        put(fill_wr, 2'b01, 1'b0, 3'($urandom), 26'($urandom));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) put(1'b0, 2'b00, 1'b0, 3'd0, 26'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11: quiet after reset
        chk(sram_ce_n && !sram_drive && !cmd_busy, "R11", "reset state",
            {29'd0, sram_ce_n, sram_drive, cmd_busy}, 32'h4);
        // basic write (R1 R5 R8 R9)
        wr(MY_ID, 2'b10, 2'b10, 0, 0, 1, 2'b01, 3'd5, 19'h1234A, 0);
        idle(LAT + 2);
        // back-to-back with write opcodes in fillers (R6 R7 R10)
        wr(MY_ID, 2'b10, 2'b10, 0, 0, 1, 2'b01, 3'd1, 19'h00011, 1);
        wr(MY_ID, 2'b10, 2'b10, 0, 0, 1, 2'b01, 3'd2, 19'h00022, 1);
        wr(MY_ID, 2'b10, 2'b10, 0, 0, 1, 2'b01, 3'd3, 19'h00033, 1);
        // R3: other device
        wr(5'd8, 2'b10, 2'b10, 0, 0, 1, 2'b01, 3'd4, 19'h00044, 0);
        // R2: wrong space in A, then in B
        wr(MY_ID, 2'b01, 2'b10, 0, 0, 1, 2'b01, 3'd4, 19'h00055, 0);
        wr(MY_ID, 2'b10, 2'b11, 0, 0, 1, 2'b01, 3'd4, 19'h00066, 0);
        // R4: burst in A, then in B
        wr(MY_ID, 2'b10, 2'b10, 1, 0, 1, 2'b01, 3'd4, 19'h00077, 0);
        wr(MY_ID, 2'b10, 2'b10, 0, 1, 1, 2'b01, 3'd4, 19'h00088, 0);
        // R1: phase B not valid, then wrong opcode
        wr(MY_ID, 2'b10, 2'b10, 0, 0, 0, 2'b01, 3'd4, 19'h00099, 0);
        wr(MY_ID, 2'b10, 2'b10, 0, 0, 1, 2'b10, 3'd4, 19'h000AA, 0);
        // R5 address extremes
        wr(MY_ID, 2'b10, 2'b10, 0, 0, 1, 2'b01, 3'd7, 19'h7FFFF, 0);
        wr(MY_ID, 2'b10, 2'b10, 0, 0, 1, 2'b01, 3'd0, 19'h00000, 0);
        idle(LAT + 2);
        // R11: reset with a write in flight
        wr(MY_ID, 2'b10, 2'b10, 0, 0, 1, 2'b01, 3'd6, 19'h0ABCD, 0);
        @(negedge clk); rst = 1'b1;
        @(negedge clk);
        @(negedge clk); rst = 1'b0;
        idle(LAT + 2);
        wr(MY_ID, 2'b10, 2'b10, 0, 0, 1, 2'b01, 3'd3, 19'h05555, 0);
        idle(LAT + 3);
        chk(exp_q.size() == 0, "R8", "pending writes left", 32'(exp_q.size()), 32'd0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(5 * 200000);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL R7 watchdog expired: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule